// File: doc/BRIEF.md
# Operand Register Bank with Built-in Constants

This block holds the sixteen 16-bit registers of a small RISC processor core and serves their source operands. Slot 0 holds the program counter, slot 1 the stack pointer and slot 2 the status word. Slot 3 has no storage. Slots 4 to 15 are free for general use. The read port takes a register number together with the 2-bit source addressing mode of the instruction.

For slots 2 and 3, some mode values select one of six fixed constants in place of the stored value, so the instruction needs no extra word to carry the value. The write port stores either a full word or a single byte. A byte write zero-extends into the upper bits. The two pointer slots always keep bit 0 clear.

When the post-increment mode is used, a separate strobe steps the register named on the read port after it has been read. The stored value is read combinationally, and every change to it lands on the rising clock edge.

Top module: `operand_regbank`

## Requirements
- R1: After reset every register holds 0, and slots 0, 1 and 4 to 15 read back 0 in mode 00.
- R2: Slot 2 read in mode 00 returns the stored status word. Slot 2 read in mode 01 returns 0.
- R3: Slot 2 returns 0x0004 in mode 10 and 0x0008 in mode 11.
- R4: Slot 3 returns 0x0000, 0x0001, 0x0002 and 0xFFFF for modes 00, 01, 10 and 11.
- R5: A constant never depends on what was last written to slot 2 or slot 3, and reading a constant never increments anything.
- R6: A write to slot 0 (program counter) or slot 1 (stack pointer) stores bit 0 as 0.
- R7: A byte write (wr_byte=1) stores wr_data[7:0] in bits 7:0 and clears bits 15:8 of the destination.
- R8: A write to slot 3 changes no register.
- R9: With inc_en=1, rd_mode=11 and a slot other than 2 or 3, a word access (inc_byte=0) adds 2 to that slot on the clock edge, wrapping modulo 2^16. With rd_mode other than 11, inc_en has no effect.
- R10: A byte post-increment (inc_byte=1) adds 1, except on slots 0 and 1, which always step by 2.
- R11: If the write port and the post-increment target the same slot in one cycle, the written value is stored. Otherwise both updates take effect.
- R12: For any slot other than 2 or 3, modes 01, 10 and 11 return the stored value unchanged.
- R13: A write shows on the read port only after the rising clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel | input | 4 | Source register number |
| rd_mode | input | 2 | Source addressing mode |
| rd_data | output | 16 | Source operand: stored value or constant |
| inc_en | input | 1 | Post-increment strobe for the read slot |
| inc_byte | input | 1 | Post-increment uses byte size |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Destination register number |
| wr_byte | input | 1 | Byte-sized write |
| wr_data | input | 16 | Write data |

## Verification
The bench builds the bank with its default values: 16-bit width and sixteen slots. At this size, every slot can be read in all four modes after each phase.

Full sweeps cover word writes, byte writes and post-increments of every slot in both sizes. Together they reach every constant, the pointer alignment, the zero-extension and the step-size exceptions. Directed cases add the write/increment collision on one slot, updates to two different slots in the same cycle, and wrap-around at 0xFFFF. A further case holds a pending write to show that the read port does not change before the clock edge.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDEXED  = 2'b01,
    AM_INDIRECT = 2'b10,
    AM_POSTINC  = 2'b11
  } amode_e;

  localparam int IDX_PC = 0;
  localparam int IDX_SP = 1;
  localparam int IDX_SR = 2;
  localparam int IDX_CG = 3;

  // post-increment distance; pointer slots always move by a word
  function automatic int unsigned step_of(input logic is_byte, input int unsigned idx);
    return (is_byte && idx > IDX_SP) ? 1 : 2;
  endfunction
endpackage

// File: rtl/opreg_cgen.sv
module opreg_cgen #(
  parameter int DW = 16
) (
  input  logic [1:0]    mode,
  input  logic          sel_sr,
  input  logic          sel_cg,
  output logic          is_const,
  output logic [DW-1:0] cval
);
  import opreg_pkg::*;

  always_comb begin
    is_const = 1'b0;
    cval     = '0;
    if (sel_cg) begin
      is_const = 1'b1;
      case (amode_e'(mode))
        AM_DIRECT:   cval = '0;
        AM_INDEXED:  cval = DW'(1);
        AM_INDIRECT: cval = DW'(2);
        default:     cval = '1;
      endcase
    end else if (sel_sr && mode != AM_DIRECT) begin
      is_const = 1'b1;
      case (amode_e'(mode))
        AM_INDEXED:  cval = '0;
        AM_INDIRECT: cval = DW'(4);
        default:     cval = DW'(8);
      endcase
    end
  end
endmodule

// File: rtl/opreg_store.sv
module opreg_store #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_sel,
  input  logic                     wr_byte,
  input  logic [DW-1:0]            wr_data,
  input  logic                     inc_fire,
  input  logic [AW-1:0]            inc_idx,
  input  logic                     inc_byte,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  import opreg_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (g == IDX_CG) begin : g_none
      assign regs_q[g] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      logic [DW-1:0] wval;
      logic          hit_wr, hit_inc;

      assign hit_wr  = wr_en && (wr_sel == AW'(g));
      assign hit_inc = inc_fire && (inc_idx == AW'(g));

      always_comb begin
        wval = wr_byte ? {{(DW-8){1'b0}}, wr_data[7:0]} : wr_data;
        if (g <= IDX_SP) wval[0] = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (hit_wr)  q <= wval;
        else if (hit_inc) q <= q + DW'(step_of(inc_byte, g));
      end

      assign regs_q[g] = q;
    end
  end
endmodule

// File: rtl/operand_regbank.sv
module operand_regbank #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_sel,
  input  logic [1:0]    rd_mode,
  output logic [DW-1:0] rd_data,
  input  logic          inc_en,
  input  logic          inc_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data
);
  import opreg_pkg::*;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           rd_word;
  logic [DW-1:0]           cval;
  logic                    is_const;
  logic                    inc_fire;
  logic                    inc_blocked;

  opreg_cgen #(.DW(DW)) u_cgen (
    .mode     (rd_mode),
    .sel_sr   (rd_sel == AW'(IDX_SR)),
    .sel_cg   (rd_sel == AW'(IDX_CG)),
    .is_const (is_const),
    .cval     (cval)
  );

  assign inc_fire    = inc_en && (rd_mode == AM_POSTINC) && !is_const;
  assign inc_blocked = inc_fire && wr_en && (wr_sel == rd_sel);

  opreg_store #(.DW(DW), .NREG(NREG)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_byte  (wr_byte),
    .wr_data  (wr_data),
    .inc_fire (inc_fire),
    .inc_idx  (rd_sel),
    .inc_byte (inc_byte),
    .regs_q   (regs_q)
  );

  assign rd_word = regs_q[rd_sel];
  assign rd_data = is_const ? cval : rd_word;
endmodule

// File: rtl/opreg_chk.sv
module opreg_chk #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NREG-1:0][DW-1:0] regs_q,
  input logic [AW-1:0]           rd_sel,
  input logic [1:0]              rd_mode,
  input logic [DW-1:0]           rd_data,
  input logic                    inc_byte,
  input logic                    inc_fire,
  input logic                    inc_blocked,
  input logic                    is_const,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_sel,
  input logic                    wr_byte,
  input logic [DW-1:0]           wr_data
);
  a_r6_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[0][0] == 1'b0 && regs_q[1][0] == 1'b0);

  a_r4_cg_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == AW'(3) && rd_mode == 2'b11) |-> rd_data == '1);

  a_r5_const_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    is_const |=> regs_q == $past(regs_q) || $past(wr_en));

  a_r7_byte_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_sel != AW'(3)) |=> regs_q[$past(wr_sel)][DW-1:8] == '0);

  a_r8_cg_write_void: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == AW'(3) && !inc_fire) |=> regs_q == $past(regs_q));

  a_r9_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && !inc_blocked && (!inc_byte || rd_sel <= AW'(1)))
      |=> regs_q[$past(rd_sel)] == $past(rd_data) + DW'(2));

  a_r10_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && !inc_blocked && inc_byte && rd_sel > AW'(1))
      |=> regs_q[$past(rd_sel)] == $past(rd_data) + DW'(1));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != AW'(3)) |=> regs_q[$past(wr_sel)][7:1] == $past(wr_data[7:1]));
endmodule

bind operand_regbank opreg_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .regs_q      (regs_q),
  .rd_sel      (rd_sel),
  .rd_mode     (rd_mode),
  .rd_data     (rd_data),
  .inc_byte    (inc_byte),
  .inc_fire    (inc_fire),
  .inc_blocked (inc_blocked),
  .is_const    (is_const),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_byte     (wr_byte),
  .wr_data     (wr_data)
);

// File: tb/sim_operand_regbank.sv
module sim_operand_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [1:0]  rd_mode = '0;
  logic [15:0] rd_data;
  logic        inc_en = 1'b0, inc_byte = 1'b0;
  logic        wr_en = 1'b0, wr_byte = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mdl [16];
  bit done = 0;

  always #5 clk = ~clk;

  operand_regbank u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int s, input int m);
    if (s == 2) begin
      case (m) 0: return mdl[2]; 1: return 16'h0000; 2: return 16'h0004; default: return 16'h0008; endcase
    end
    if (s == 3) begin
      case (m) 0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0002; default: return 16'hFFFF; endcase
    end
    return mdl[s];
  endfunction

  function automatic string tag_of(input int s, input int m, input string base);
    if (s == 2) return (m == 0) ? "R2" : (m == 1) ? "R2" : "R3";
    if (s == 3) return "R4";
    return (m == 0) ? base : "R12";
  endfunction

  // combinational read, sampled between edges
  task automatic sweep(input string base);
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++) begin
        rd_sel = 4'(s); rd_mode = 2'(m); #1;
        chk(tag_of(s, m, base), rd_data, exp_rd(s, m));
      end
  endtask

  task automatic do_wr(input int s, input bit b, input logic [15:0] d);
    logic [15:0] v;
    @(negedge clk);
    wr_en = 1; wr_sel = 4'(s); wr_byte = b; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_byte = 0;
    v = b ? {8'h00, d[7:0]} : d;
    if (s <= 1) v[0] = 1'b0;
    if (s != 3) mdl[s] = v;
  endtask

  task automatic do_inc(input int s, input bit b);
    @(negedge clk);
    rd_sel = 4'(s); rd_mode = 2'b11; inc_en = 1; inc_byte = b;
    @(negedge clk);
    inc_en = 0; inc_byte = 0;
    if (s != 2 && s != 3) mdl[s] = mdl[s] + ((b && s > 1) ? 16'd1 : 16'd2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sweep("R1");

    // R6 R13 word writes: odd data shows pointer alignment
    for (int s = 0; s < 16; s++) do_wr(s, 0, 16'hA5C3 ^ 16'(s * 16'h1111));
    sweep("R6");
    chk("R6", mdl[0][0] == 1'b0 ? 16'd1 : 16'd0, 16'd1);

    // R13: pending write not visible before edge
    @(negedge clk);
    wr_en = 1; wr_sel = 4'd9; wr_data = 16'h1357; rd_sel = 4'd9; rd_mode = 2'b00;
    #2; chk("R13", rd_data, mdl[9]);
    @(posedge clk); #1;
    chk("R13", rd_data, 16'h1357);
    @(negedge clk); wr_en = 0; mdl[9] = 16'h1357;

    // R5: write status word then constants stay fixed
    do_wr(2, 0, 16'hFFFF);
    for (int m = 1; m < 4; m++) begin
      rd_sel = 4'd2; rd_mode = 2'(m); #1; chk("R5", rd_data, exp_rd(2, m));
    end

    // R7 byte writes
    for (int s = 0; s < 16; s++) do_wr(s, 1, 16'hBEEF ^ 16'(s * 16'h0707));
    sweep("R7");

    // R8: write to slot 3 leaves everything as is
    do_wr(3, 0, 16'h7777);
    sweep("R8");

    // R9 R10 post-increment sweep both sizes
    for (int s = 0; s < 16; s++) do_inc(s, 0);
    sweep("R9");
    for (int s = 0; s < 16; s++) do_inc(s, 1);
    sweep("R10");

    // R9 wrap and mode gating
    do_wr(5, 0, 16'hFFFF); do_inc(5, 0);
    rd_sel = 4'd5; rd_mode = 2'b00; #1; chk("R9", rd_data, 16'h0001);
    do_wr(6, 0, 16'hFFFF); do_inc(6, 1);
    rd_sel = 4'd6; rd_mode = 2'b00; #1; chk("R10", rd_data, 16'h0000);
    @(negedge clk);
    rd_sel = 4'd7; rd_mode = 2'b10; inc_en = 1;
    @(negedge clk); inc_en = 0; rd_mode = 2'b00; #1;
    chk("R9", rd_data, mdl[7]);

    // R11 collision and parallel update
    @(negedge clk);
    rd_sel = 4'd7; rd_mode = 2'b11; inc_en = 1; wr_en = 1; wr_sel = 4'd7; wr_data = 16'h4242;
    @(negedge clk);
    inc_en = 0; wr_en = 0; rd_mode = 2'b00; #1;
    mdl[7] = 16'h4242;
    chk("R11", rd_data, 16'h4242);
    @(negedge clk);
    rd_sel = 4'd9; rd_mode = 2'b11; inc_en = 1; wr_en = 1; wr_sel = 4'd8; wr_data = 16'h0C0C;
    @(negedge clk);
    inc_en = 0; wr_en = 0;
    mdl[8] = 16'h0C0C; mdl[9] = mdl[9] + 16'd2;
    sweep("R11");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule